// File: doc/BRIEF.md
# Robbed-Bit Signaling Supervisor

This block watches a serial PCM stream that has already been retimed to the system clock. The stream arrives with its current channel, bit and frame position. On the least significant bit of each channel in the signaling frames, the block picks up that channel's robbed signaling bits. It keeps a per-channel four-bit signaling state, {A,B,C,D}. While the position inputs name a channel, the A to D outputs show that channel's state, and they repeat it in every frame of the multiframe. The stored state changes only at multiframe boundaries.

Two mechanisms guard the stored state.

- **Integration.** This is a debounce across multiframes. A new per-channel state must be seen in enough consecutive multiframes before it is published.
- **Freeze.** A slip pulse, or the inhibit input held low, blocks publication for one or two multiframes. An inhibit held low blocks it for as long as it stays low.

A freeze flag reports the frozen condition. In one mode the block also forces the robbed-bit positions of the passing serial stream to ones.

Top module: `rbs_supervisor`

## Requirements
- R1: In extended framing (`ext_frm`=1), a strobed bit with `bit_idx`=7 (the channel LSB) is captured as follows. Frame 6 gives A, frame 12 gives B, frame 18 gives C and frame 24 gives D, with `frame_num` counting from 1. These four bits form the channel word {A,B,C,D}, with A as bit 3. No other bit or frame changes it.
- R2: In 12-frame framing (`ext_frm`=0), only frames 6 and 12 are captured. The published C and D are the A and B values of the previous multiframe.
- R3: `sig_a`..`sig_d` always show the published word of the channel that `chan_idx` selects. They change only when a new word is published for that channel.
- R4: A multiframe boundary is a strobe with `frame_num`=1, `chan_idx`=0 and `bit_idx`=0. Publication happens only at a boundary. The first boundary after reset only starts the collection, so the outputs stay zero until a full multiframe has been collected.
- R5: Integration depth is set by `mode`:
  - 00 and 11: 1 multiframe.
  - 01: 2 multiframes.
  - 10: 5 multiframes in 12-frame framing, 3 in extended framing.

  A channel's word is published once it has been identical at that many consecutive boundaries.
- R6: A `slip` pulse, or `inhibit_n` low, raises `freeze_flag` on the next cycle. Publication then stays blocked while `inhibit_n` is low. After the last trigger, the next F boundaries are also blocked, where F is 1 for modes 00 and 11 and 2 for modes 01 and 10.
- R7: `freeze_flag` falls only at the first boundary where publication is allowed.
- R8: At a publication that ends a freeze, integration depth is capped at 2.
- R9: In mode 11, `ser_out` is forced to 1 on the LSB of every channel in the signaling frames of the current framing. Otherwise `ser_out` equals `ser_in`.
- R10: After reset, `freeze_flag` is 0 and every channel's published word is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bit_strobe | input | 1 | A stream bit is present this cycle |
| ser_in | input | 1 | Retimed serial data bit |
| chan_idx | input | CHW | Current channel, 0-based |
| bit_idx | input | 3 | Bit within channel, 0 = MSB, 7 = LSB |
| frame_num | input | 5 | Frame within multiframe, 1-based |
| ext_frm | input | 1 | 1 = 24-frame framing, 0 = 12-frame framing |
| mode | input | 2 | Integration/freeze mode |
| inhibit_n | input | 1 | Active-low signaling update inhibit |
| slip | input | 1 | One-cycle slip indication |
| ser_out | output | 1 | Serial data, robbed bits forced to one in mode 11 |
| sig_a | output | 1 | Published A of the selected channel |
| sig_b | output | 1 | Published B of the selected channel |
| sig_c | output | 1 | Published C of the selected channel |
| sig_d | output | 1 | Published D of the selected channel |
| freeze_flag | output | 1 | Signaling updates are frozen |

## Verification
The bench fills every non-signaling bit with ones, so a design that sampled the wrong bit or frame would publish ones where zeros are expected. The 12-frame test checks the lag of C and D by one multiframe; copying the wrong generation would show the current A and B twice. Integration tests hold the old word until the last required multiframe. An off-by-one counter, or a counter that is not cleared when the candidate changes, publishes a multiframe early. The freeze tests count blocked boundaries after a slip and after an inhibit release, and they include a case where only the depth-2 cap lets the word through; a design without the cap would stay frozen on the old word.

// File: rtl/rbs_supervisor.sv
module rbs_supervisor #(
  parameter int NCH = 24,
  parameter int CHW = $clog2(NCH)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           bit_strobe,
  input  logic           ser_in,
  input  logic [CHW-1:0] chan_idx,
  input  logic [2:0]     bit_idx,
  input  logic [4:0]     frame_num,
  input  logic           ext_frm,
  input  logic [1:0]     mode,
  input  logic           inhibit_n,
  input  logic           slip,
  output logic           ser_out,
  output logic           sig_a,
  output logic           sig_b,
  output logic           sig_c,
  output logic           sig_d,
  output logic           freeze_flag
);

  localparam int AGW = 3;
  localparam logic [AGW-1:0] AG_MAX = '1;

  logic [NCH-1:0] cap_a, cap_b, cap_c, cap_d;
  logic [3:0]     cand  [NCH];
  logic [AGW-1:0] agree [NCH];
  logic [3:0]     held  [NCH];
  logic [3:0]     word  [NCH];
  logic [AGW-1:0] eff   [NCH];
  logic [1:0]     frz_left;
  logic           primed;
  logic [AGW-1:0] need_full, need;

  wire lsb       = bit_strobe && (bit_idx == 3'd7);
  wire mf_edge   = bit_strobe && (frame_num == 5'd1) && (chan_idx == '0) && (bit_idx == 3'd0);
  wire sig_frame = (frame_num == 5'd6) || (frame_num == 5'd12) ||
                   (ext_frm && ((frame_num == 5'd18) || (frame_num == 5'd24)));
  wire trig      = slip || !inhibit_n;
  wire [1:0] frz_len = (mode == 2'b01 || mode == 2'b10) ? 2'd2 : 2'd1;
  wire upd_ok    = mf_edge && primed && !trig && (frz_left == 2'd0);

  assign ser_out = ser_in | (lsb && sig_frame && (mode == 2'b11));
  assign {sig_a, sig_b, sig_c, sig_d} = held[chan_idx];

  always_comb begin
    case (mode)
      2'b01:   need_full = 3'd2;
      2'b10:   need_full = ext_frm ? 3'd3 : 3'd5;
      default: need_full = 3'd1;
    endcase
  end
  assign need = (freeze_flag && need_full > 3'd2) ? 3'd2 : need_full;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cap_a <= '0; cap_b <= '0; cap_c <= '0; cap_d <= '0;
    end else if (lsb) begin
      if (frame_num == 5'd6)              cap_a[chan_idx] <= ser_in;
      if (frame_num == 5'd12)             cap_b[chan_idx] <= ser_in;
      if (ext_frm && frame_num == 5'd18)  cap_c[chan_idx] <= ser_in;
      if (ext_frm && frame_num == 5'd24)  cap_d[chan_idx] <= ser_in;
    end else if (mf_edge && !ext_frm) begin
      cap_c <= cap_a;
      cap_d <= cap_b;
    end
  end

  for (genvar g = 0; g < NCH; g++) begin : g_chan
    assign word[g] = {cap_a[g], cap_b[g], cap_c[g], cap_d[g]};
    assign eff[g]  = (word[g] != cand[g]) ? 3'd1 :
                     (agree[g] == AG_MAX) ? AG_MAX : agree[g] + 3'd1;

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        cand[g]  <= '0;
        agree[g] <= '0;
        held[g]  <= '0;
      end else if (mf_edge && primed) begin
        cand[g]  <= word[g];
        agree[g] <= eff[g];
        if (upd_ok && eff[g] >= need) held[g] <= word[g];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      frz_left    <= '0;
      freeze_flag <= 1'b0;
      primed      <= 1'b0;
    end else begin
      if (mf_edge) primed <= 1'b1;
      if (trig) begin
        frz_left    <= frz_len;
        freeze_flag <= 1'b1;
      end else if (mf_edge && primed && frz_left != 2'd0) begin
        frz_left <= frz_left - 2'd1;
      end else if (upd_ok) begin
        freeze_flag <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/rbs_supervisor_chk.sv
module rbs_supervisor_chk #(
  parameter int CHW = 5
) (
  input logic           clk,
  input logic           rst_n,
  input logic           bit_strobe,
  input logic           ser_in,
  input logic [CHW-1:0] chan_idx,
  input logic [2:0]     bit_idx,
  input logic [4:0]     frame_num,
  input logic           ext_frm,
  input logic [1:0]     mode,
  input logic           inhibit_n,
  input logic           slip,
  input logic           ser_out,
  input logic           sig_a,
  input logic           sig_b,
  input logic           sig_c,
  input logic           sig_d,
  input logic           freeze_flag
);

  wire       at_edge = bit_strobe && frame_num == 5'd1 && chan_idx == '0 && bit_idx == 3'd0;
  wire [3:0] sigs    = {sig_a, sig_b, sig_c, sig_d};

  // R6
  freeze_on_slip_chk: assert property (@(posedge clk) disable iff (!rst_n)
    slip |=> freeze_flag);

  // R6
  freeze_on_inhibit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !inhibit_n |=> freeze_flag);

  // R6
  inhibit_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !inhibit_n |=> (!$stable(chan_idx) || $stable(sigs)));

  // R4
  edge_only_update_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !at_edge |=> (!$stable(chan_idx) || $stable(sigs)));

  // R7
  unfreeze_at_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(freeze_flag) |-> $past(at_edge && inhibit_n && !slip));

  // R9
  ones_forced_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'b11 && bit_strobe && bit_idx == 3'd7 && frame_num == 5'd12) |-> ser_out);

  // R9
  passthru_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode != 2'b11) |-> (ser_out == ser_in));

endmodule

bind rbs_supervisor rbs_supervisor_chk #(.CHW(CHW)) u_chk (
  .clk(clk), .rst_n(rst_n), .bit_strobe(bit_strobe), .ser_in(ser_in),
  .chan_idx(chan_idx), .bit_idx(bit_idx), .frame_num(frame_num),
  .ext_frm(ext_frm), .mode(mode), .inhibit_n(inhibit_n), .slip(slip),
  .ser_out(ser_out), .sig_a(sig_a), .sig_b(sig_b), .sig_c(sig_c),
  .sig_d(sig_d), .freeze_flag(freeze_flag)
);

// File: tb/rbs_supervisor_bench.sv
module rbs_supervisor_bench;
  localparam int NCH = 4;
  localparam int CHW = 2;

  logic clk = 0;
  logic rst_n, bit_strobe, ser_in, ext_frm, inhibit_n, slip;
  logic [CHW-1:0] chan_idx;
  logic [2:0] bit_idx;
  logic [4:0] frame_num;
  logic [1:0] mode;
  logic ser_out, sig_a, sig_b, sig_c, sig_d, freeze_flag;
  int nchk = 0, nfail = 0;

  always #10 clk = ~clk;

  rbs_supervisor #(.NCH(NCH), .CHW(CHW)) u_rbs_supervisor (
    .clk(clk), .rst_n(rst_n), .bit_strobe(bit_strobe), .ser_in(ser_in),
    .chan_idx(chan_idx), .bit_idx(bit_idx), .frame_num(frame_num),
    .ext_frm(ext_frm), .mode(mode), .inhibit_n(inhibit_n), .slip(slip),
    .ser_out(ser_out), .sig_a(sig_a), .sig_b(sig_b), .sig_c(sig_c),
    .sig_d(sig_d), .freeze_flag(freeze_flag));

  task automatic chk(string req, logic [15:0] act, logic [15:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic do_reset(logic ext, logic [1:0] m);
    @(negedge clk);
    rst_n = 0; bit_strobe = 0; ser_in = 0; chan_idx = '0; bit_idx = '0;
    frame_num = 5'd1; ext_frm = ext; mode = m; inhibit_n = 1; slip = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
  endtask

  task automatic drive_bit(int fr, int ch, int b, logic d);
    @(negedge clk);
    bit_strobe = 1; frame_num = 5'(fr); chan_idx = CHW'(ch); bit_idx = 3'(b); ser_in = d;
  endtask

  task automatic idle();
    @(negedge clk);
    bit_strobe = 0; ser_in = 0;
  endtask

  task automatic body(logic [15:0] pat);
    int nfr = ext_frm ? 24 : 12;
    for (int fr = 1; fr <= nfr; fr++)
      for (int ch = 0; ch < NCH; ch++)
        for (int b = 0; b < 8; b++) begin
          logic d;
          if (fr == 1 && ch == 0 && b == 0) continue;
          d = 1'b1;
          if (b == 7) begin
            if (fr == 6)  d = pat[ch*4+3];
            if (fr == 12) d = pat[ch*4+2];
            if (fr == 18) d = pat[ch*4+1];
            if (fr == 24) d = pat[ch*4+0];
          end
          drive_bit(fr, ch, b, d);
        end
    idle();
  endtask

  task automatic boundary();
    drive_bit(1, 0, 0, 1'b1);
    idle();
  endtask

  task automatic tick(logic [15:0] pat);
    body(pat);
    boundary();
  endtask

  task automatic check_all(string req, logic [15:0] exp);
    logic [15:0] act;
    for (int ch = 0; ch < NCH; ch++) begin
      @(negedge clk);
      chan_idx = CHW'(ch);
      #1 act[ch*4 +: 4] = {sig_a, sig_b, sig_c, sig_d};
    end
    chk(req, act, exp);
  endtask

  task automatic check_frz(string req, logic exp);
    #1 chk(req, {15'd0, freeze_flag}, {15'd0, exp});
  endtask

  task automatic pulse_slip();
    @(negedge clk); slip = 1;
    @(negedge clk); slip = 0;
  endtask

  function automatic logic [15:0] d4_exp(logic [15:0] cur, logic [15:0] prev);
    logic [15:0] r;
    for (int ch = 0; ch < NCH; ch++)
      r[ch*4 +: 4] = {cur[ch*4+3], cur[ch*4+2], prev[ch*4+3], prev[ch*4+2]};
    return r;
  endfunction

  task automatic t_reset();
    do_reset(1, 2'b00);
    check_frz("R10 freeze after reset", 1'b0);
    check_all("R10 words after reset", 16'h0000);
  endtask

  task automatic t_extract();
    do_reset(1, 2'b00);
    boundary();
    body(16'h5A3C);
    check_all("R4 no publish before boundary", 16'h0000);
    boundary();
    check_all("R1 R3 extraction ext framing", 16'h5A3C);
    tick(16'hC381);
    check_all("R1 second pattern", 16'hC381);
  endtask

  task automatic t_d4();
    do_reset(0, 2'b00);
    boundary();
    tick(16'h84C4);
    check_all("R2 first 12-frame mf", d4_exp(16'h84C4, 16'h0000));
    tick(16'h48C8);
    check_all("R2 C/D carry previous A/B", d4_exp(16'h48C8, 16'h84C4));
  endtask

  task automatic t_integ2();
    do_reset(1, 2'b01);
    boundary();
    tick(16'h1234);
    check_all("R5 depth2 not yet", 16'h0000);
    tick(16'h1234);
    check_all("R5 depth2 published", 16'h1234);
    tick(16'hFEDC);
    check_all("R5 depth2 hold old", 16'h1234);
    tick(16'hFEDC);
    check_all("R5 depth2 new", 16'hFEDC);
  endtask

  task automatic t_integ3();
    do_reset(1, 2'b10);
    boundary();
    tick(16'h9A5F);
    tick(16'h9A5F);
    check_all("R5 depth3 after 2", 16'h0000);
    tick(16'h9A5F);
    check_all("R5 depth3 after 3", 16'h9A5F);
  endtask

  task automatic t_integ5();
    do_reset(0, 2'b10);
    boundary();
    for (int k = 0; k < 5; k++) tick(16'hCCCC);
    check_all("R5 depth5 12-frame held", 16'h0000);
    tick(16'hCCCC);
    check_all("R5 depth5 12-frame published", 16'hFFFF);
  endtask

  task automatic t_slip();
    do_reset(1, 2'b00);
    boundary();
    tick(16'h2468);
    pulse_slip();
    check_frz("R6 slip raises freeze", 1'b1);
    tick(16'h1357);
    check_all("R6 slip blocks one mf", 16'h2468);
    check_frz("R7 still frozen", 1'b1);
    tick(16'h1357);
    check_all("R6 update after freeze", 16'h1357);
    check_frz("R7 freeze cleared", 1'b0);
  endtask

  task automatic t_cap();
    do_reset(1, 2'b10);
    boundary();
    for (int k = 0; k < 3; k++) tick(16'hA0A0);
    check_all("R5 prestate", 16'hA0A0);
    pulse_slip();
    tick(16'h0F0F);
    tick(16'h5555);
    check_all("R6 two mf blocked", 16'hA0A0);
    tick(16'h5555);
    check_all("R8 cap at two", 16'h5555);
    check_frz("R7 freeze cleared after cap", 1'b0);
  endtask

  task automatic t_inhibit();
    do_reset(1, 2'b00);
    boundary();
    tick(16'h7E81);
    @(negedge clk); inhibit_n = 0;
    tick(16'h18E7);
    tick(16'h18E7);
    check_all("R6 inhibit blocks", 16'h7E81);
    check_frz("R6 inhibit freeze", 1'b1);
    @(negedge clk); inhibit_n = 1;
    tick(16'h18E7);
    check_all("R6 post-inhibit freeze", 16'h7E81);
    tick(16'h18E7);
    check_all("R6 update after inhibit", 16'h18E7);
    check_frz("R7 cleared after inhibit", 1'b0);
  endtask

  task automatic t_ones();
    do_reset(1, 2'b11);
    drive_bit(6, 1, 7, 1'b0);  #1 chk("R9 frame6 forced", {15'd0, ser_out}, 16'd1);
    drive_bit(24, 2, 7, 1'b0); #1 chk("R9 frame24 forced", {15'd0, ser_out}, 16'd1);
    drive_bit(7, 1, 7, 1'b0);  #1 chk("R9 non-sig frame passes", {15'd0, ser_out}, 16'd0);
    drive_bit(6, 1, 3, 1'b0);  #1 chk("R9 non-LSB passes", {15'd0, ser_out}, 16'd0);
    idle();
    @(negedge clk); ext_frm = 0;
    drive_bit(18, 0, 7, 1'b0); #1 chk("R9 frame18 in 12-frame", {15'd0, ser_out}, 16'd0);
    idle();
    @(negedge clk); mode = 2'b00; ext_frm = 1;
    drive_bit(6, 1, 7, 1'b0);  #1 chk("R9 mode00 passes", {15'd0, ser_out}, 16'd0);
    idle();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", nchk, nfail);
    $finish;
  end

  initial begin
    t_reset();
    t_extract();
    t_d4();
    t_integ2();
    t_integ3();
    t_integ5();
    t_slip();
    t_cap();
    t_inhibit();
    t_ones();
    $display("[TB] %0d tests run, %0d failed", nchk, nfail);
    $finish;
  end
endmodule